// File: doc/BRIEF.md
# Keypad Security Code Checker

This block sits behind a keypad front end and decides whether an entered digit sequence unlocks a protected function. Each key press arrives as a clean one-cycle strobe with a 4-bit digit. The digit is shifted into an entry register. A one-hot marker advances one place per accepted press, so the block knows when a full code has been typed. The entry length is the `DIGITS` parameter, and the marker's width follows from it.

When the final digit arrives, the whole entry is compared with a stored code. A match raises `disarm`, which stays high until a re-arm pulse. A miss discards the attempt and restarts entry. The stored code lives in its own register and is written through a configuration port. It is independent of any attempt in progress.

Top module: `kc_code_checker`

## Requirements
- R1: After reset, `disarm` is low, the stored code is all zeros, and entry starts at the first digit.
- R2: Digits are compared in entry order. The first accepted digit is checked against stored-code bits [4*DIGITS-1:4*DIGITS-4], and the last one against bits [3:0].
- R3: A code is complete after exactly DIGITS accepted presses. Fewer presses never raise `disarm`, however long the pause between them.
- R4: When the completing press makes all entered digits equal to the stored code, `disarm` is high from the next clock edge on.
- R5: A completed entry that differs in any digit leaves `disarm` low. The next DIGITS presses then form a fresh attempt.
- R6: `disarm` stays high until `rearm` is sampled high. `rearm` drives `disarm` low and discards any partly entered digits.
- R7: Key presses while `disarm` is high are ignored and cannot lower `disarm`.
- R8: `cfg_we` loads `cfg_code` as the stored code from the next edge on. An attempt that completes in the same cycle as a write is compared with the old code.
- R9: A key strobe in the same cycle as `rearm` is discarded.
- R10: With DIGITS=5, five presses are needed, and a 20-bit code is compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_vld | input | 1 | One-cycle key press strobe |
| key_digit | input | 4 | Digit of the current press |
| cfg_we | input | 1 | Stored-code write enable |
| cfg_code | input | 4*DIGITS | New stored code, first digit in the top nibble |
| rearm | input | 1 | Clears `disarm` and restarts entry |
| disarm | output | 1 | High after a matching code until re-armed |

## Verification
The bench goes after several ordering and counting faults:
- It enters the right digits in reverse order. A design that compared the nibbles backwards would disarm there.
- It stops one press short and then waits. An off-by-one marker would fire early.
- It types a wrong code and then the right one. If the mismatch did not reload the marker, the second attempt would end at the wrong press.
- It presses keys while disarmed, rewrites the code on the completing press, and strobes a key during re-arm. These expose a design that re-evaluates while unlocked, compares against the freshly written code, or lets a discarded press advance entry.

// File: rtl/kc_pkg.sv
package kc_pkg;
  localparam int KC_DIGIT_W = 4;
  typedef logic [KC_DIGIT_W-1:0] kc_digit_t;

  // bit index of the marker slot that means "this press completes the code"
  function automatic int kc_last_slot(input int digits);
    return digits - 1;
  endfunction
endpackage

// File: rtl/kc_store.sv
module kc_store #(
  parameter int CODE_W = 16,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] wdata,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  code <= RESET_CODE;
    else if (we) code <= wdata;
  end

  AST_STORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> code == $past(wdata)); // R8
  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(code)); // R8
endmodule

// File: rtl/kc_marker.sv
module kc_marker
  import kc_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [DIGITS-1:0] mark,
  output logic              done
);
  localparam int LAST = kc_last_slot(DIGITS);
  localparam logic [DIGITS-1:0] PRELOAD = {{(DIGITS-1){1'b0}}, 1'b1};

  assign done = step & mark[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mark <= PRELOAD;
    else if (restart || done)  mark <= PRELOAD;
    else if (step)             mark <= mark << 1;
  end

  AST_MARK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mark)); // R3
  AST_MARK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (done || restart) |=> mark == PRELOAD); // R5
  AST_MARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(mark)); // R3
endmodule

// File: rtl/kc_entry.sv
module kc_entry
  import kc_pkg::*;
#(
  parameter int DIGITS = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clear,
  input  logic                           shift,
  input  kc_digit_t                      digit,
  output logic [DIGITS*KC_DIGIT_W-1:0]   entry,
  output logic [DIGITS*KC_DIGIT_W-1:0]   entry_next
);
  localparam int CODE_W = DIGITS * KC_DIGIT_W;

  function automatic logic [CODE_W-1:0] push_digit(input logic [CODE_W-1:0] cur,
                                                   input kc_digit_t d);
    logic [CODE_W-1:0] r;
    r = cur << KC_DIGIT_W;
    r[KC_DIGIT_W-1:0] = d;
    return r;
  endfunction

  assign entry_next = shift ? push_digit(entry, digit) : entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     entry <= '0;
    else if (clear) entry <= '0;
    else if (shift) entry <= entry_next;
  end

  AST_ENTRY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> entry == '0); // R6
  AST_ENTRY_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clear) |=> entry[KC_DIGIT_W-1:0] == $past(digit)); // R2
endmodule

// File: rtl/kc_code_checker.sv
module kc_code_checker
  import kc_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter logic [DIGITS*4-1:0] RESET_CODE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                key_vld,
  input  logic [3:0]          key_digit,
  input  logic                cfg_we,
  input  logic [DIGITS*4-1:0] cfg_code,
  input  logic                rearm,
  output logic                disarm
);
  localparam int CODE_W = DIGITS * KC_DIGIT_W;

  logic              key_take;
  logic              entry_done;
  logic              code_hit;
  logic [DIGITS-1:0] mark;
  logic [CODE_W-1:0] entry_q, entry_next, stored;

  // presses count only while armed and not being re-armed
  assign key_take = key_vld & ~rearm & ~disarm;

  kc_store #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_store (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_code), .code(stored));

  kc_marker #(.DIGITS(DIGITS)) u_marker (
    .clk(clk), .rst_n(rst_n), .restart(rearm), .step(key_take),
    .mark(mark), .done(entry_done));

  kc_entry #(.DIGITS(DIGITS)) u_entry (
    .clk(clk), .rst_n(rst_n), .clear(rearm | entry_done), .shift(key_take),
    .digit(kc_digit_t'(key_digit)), .entry(entry_q), .entry_next(entry_next));

  assign code_hit = (entry_next == stored);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       disarm <= 1'b0;
    else if (rearm)                   disarm <= 1'b0;
    else if (entry_done && code_hit)  disarm <= 1'b1;
  end

  AST_DISARM_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disarm) |-> $past(entry_done)); // R4
  AST_DISARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !rearm) |=> disarm); // R6
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !disarm); // R6
  AST_IGNORE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !rearm) |=> $stable(entry_q) && $stable(mark)); // R7
  AST_REARM_DROPS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> mark[0]); // R9
endmodule

// File: tb/kc_code_checker_bench.sv
module kc_code_checker_bench;
  localparam int CLK_P = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_vld = 1'b0, cfg_we = 1'b0, rearm = 1'b0;
  logic [3:0] key_digit = '0;
  logic [N*4-1:0] cfg_code = '0;
  logic disarm;

  logic k5_vld = 1'b0, k5_we = 1'b0, k5_rearm = 1'b0;
  logic [3:0] k5_dig = '0;
  logic [19:0] k5_code = '0;
  logic k5_disarm;

  int n_cmp = 0, n_bad = 0;
  bit exp_q[$];
  string tag_q[$];
  string cur_req = "R1";

  // reference model state
  bit m_dis = 0;
  int m_cnt = 0;
  int m_digits[$];
  int m_store[N] = '{0, 0, 0, 0};

  always #(CLK_P/2) clk = ~clk;

  kc_code_checker #(.DIGITS(N)) u_kc_code_checker (
    .clk(clk), .rst_n(rst_n), .key_vld(key_vld), .key_digit(key_digit),
    .cfg_we(cfg_we), .cfg_code(cfg_code), .rearm(rearm), .disarm(disarm));

  kc_code_checker #(.DIGITS(5)) u_five (
    .clk(clk), .rst_n(rst_n), .key_vld(k5_vld), .key_digit(k5_dig),
    .cfg_we(k5_we), .cfg_code(k5_code), .rearm(k5_rearm), .disarm(k5_disarm));

  task automatic check(input bit act, input bit exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: disarm=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected value queued
  task automatic cyc(input bit v, input int d, input bit we, input logic [15:0] code,
                     input bit rr);
    bit hit;
    @(negedge clk);
    key_vld = v; key_digit = 4'(d); cfg_we = we; cfg_code = code; rearm = rr;
    if (rr) begin
      m_dis = 0; m_cnt = 0; m_digits.delete();
    end else if (v && !m_dis) begin
      m_digits.push_back(d);
      m_cnt++;
      if (m_cnt == N) begin
        hit = 1;
        for (int i = 0; i < N; i++) if (m_digits[i] != m_store[i]) hit = 0;
        if (hit) m_dis = 1;
        m_cnt = 0; m_digits.delete();
      end
    end
    if (we) for (int i = 0; i < N; i++) m_store[i] = int'(code[(N-1-i)*4 +: 4]);
    exp_q.push_back(m_dis);
    tag_q.push_back(cur_req);
  endtask

  task automatic key(input int d);     cyc(1, d, 0, '0, 0); endtask
  task automatic idle(input int n);    for (int i = 0; i < n; i++) cyc(0, 0, 0, '0, 0); endtask
  task automatic do_rearm();           cyc(0, 0, 0, '0, 1); endtask
  task automatic code4(input int a, input int b, input int c, input int e);
    key(a); key(b); key(c); key(e);
  endtask

  // monitor: pops expected values a quarter period after each edge
  initial forever begin
    @(posedge clk);
    #(CLK_P/4);
    if (exp_q.size() > 0) check(disarm, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic k5_press(input int d);
    @(negedge clk); k5_vld = 1; k5_dig = 4'(d);
    @(negedge clk); k5_vld = 0;
  endtask

  initial begin
    #(CLK_P*100000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P*3);
    check(disarm, 1'b0, "R1");
    @(negedge clk); rst_n = 1'b1;
    check(disarm, 1'b0, "R1");
    // R1: stored code is zero after reset
    cur_req = "R1"; code4(0, 0, 0, 0); idle(2); do_rearm();
    // R8 write, then R2/R4 in-order match
    cur_req = "R8"; cyc(0, 0, 1, 16'h7645, 0); idle(1);
    cur_req = "R4"; code4(7, 6, 4, 5); idle(1); do_rearm();
    // R2: reversed order must not match; R5 fresh attempt afterwards
    cur_req = "R2"; code4(5, 4, 6, 7); idle(2);
    cur_req = "R5"; code4(7, 6, 4, 9); idle(1); code4(7, 6, 4, 5); idle(1);
    // R7: presses while disarmed are ignored
    cur_req = "R7"; code4(1, 1, 1, 1); key(3); idle(2); do_rearm();
    // R6: partial entry discarded by rearm
    cur_req = "R6"; key(7); key(6); do_rearm(); code4(7, 6, 4, 5); idle(1); do_rearm();
    // R3: three presses with a long pause, then the fourth
    cur_req = "R3"; key(7); key(6); key(4); idle(6); key(5); idle(1); do_rearm();
    // R9: key strobe during rearm is dropped
    cur_req = "R9"; key(7); cyc(1, 7, 0, '0, 1); code4(7, 6, 4, 5); idle(1); do_rearm();
    // R8: write on the completing press uses the old code
    cur_req = "R8"; key(7); key(6); key(4); cyc(1, 5, 1, 16'h1234, 0); idle(1); do_rearm();
    code4(1, 2, 3, 5); idle(1); code4(1, 2, 3, 4); idle(2);
    wait (exp_q.size() == 0);
    @(posedge clk); #(CLK_P/4);
    // R10: five-digit instance
    @(negedge clk); k5_we = 1; k5_code = 20'h13579;
    @(negedge clk); k5_we = 0;
    k5_press(1); k5_press(3); k5_press(5); k5_press(7);
    check(k5_disarm, 1'b0, "R10");
    k5_press(9);
    check(k5_disarm, 1'b1, "R10");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule